// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This peripheral watches for stalled software on a small 32-bit register bus. A down-counter is loaded from a programmable limit and runs while the watchdog is switched on. When the counter runs out, the block raises an interrupt, reloads the counter from the limit and keeps counting. Software must answer by servicing the watchdog through the control register.

A second stage gives software a fixed grace window of `GRACE_CYCLES` clocks after the first expiry. When the system-reset function is on and no service arrives within that window, the block drives a registered system reset output. By default this output is a single-cycle pulse. With `HOLD_RESET=1` it stays high until the block itself is reset. Acknowledging the interrupt alone does not stop the grace window. Only a service does.

The bus is a simple combinational-read, single-cycle-write interface. It uses byte offsets 0x0 (control), 0x4 (limit), 0x8 (live count, read-only) and 0xC (interrupt acknowledge, write-only). Writes take effect at the clock edge on which `bus_we` is sampled high.

Top module: `wdog_two_stage`

## Requirements
- R1: After a synchronous reset the control register reads 0, `irq_o` is 0 and `sys_rst_o` is 0.
- R2: A write to offset 0x4 stores the limit and loads the live counter with the same value at the same edge. Offset 0x4 reads back the limit, and offset 0x8 reads the live count. Writes to 0x8 are ignored.
- R3: In the control register at offset 0x0, bit 0 switches the counter on and bit 2 switches the system-reset function on. Both read back. Bit 1 (service) always reads 0.
- R4: While bit 0 is set, the count falls by one per clock. At an edge where the count is 0, the counter reloads the limit instead and `irq_o` goes high after that edge. Counting continues.
- R5: Writing 1 in bit 0 at offset 0xC clears `irq_o` after the write edge. Writing 0 there has no effect, and offset 0xC reads 0.
- R6: A control write with bit 1 set reloads the counter from the limit, clears `irq_o` and cancels a running grace window, so no system reset follows from the earlier expiry.
- R7: While bit 0 is clear, the live count holds its value and the grace window does not advance.
- R8: With bits 0 and 2 set and no service, `sys_rst_o` goes high exactly `GRACE_CYCLES` clocks after the edge of the first expiry, for exactly one cycle (default pulse mode).
- R9: Acknowledging the interrupt at 0xC does not stop the grace window. The window advances only on clocks where control bits 0 and 2 are both set, so clearing bit 2 delays the reset by the number of paused clocks.
- R10: When an expiry and an interrupt acknowledge fall on the same edge, `irq_o` ends up set. When an expiry and a service fall on the same edge, the service wins: the counter reloads and `irq_o` stays clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for `bus_addr` |
| irq_o | output | 1 | Timeout interrupt flag |
| sys_rst_o | output | 1 | Registered system reset request |

## Verification
The interrupt flag has one setting source and two clearing sources, so the bench lines up the collisions on purpose. An acknowledge write is placed so that its write edge is the exact edge where the count is zero. The bench then expects the flag to be high on the next sample. A service write is aimed at the same kind of edge, and the bench then expects the reloaded limit in the count register and a low flag one cycle later. A discrepancy in either collision shows up as a wrong flag level. The grace-window checks sample the reset output in the cycle before, at and after the computed firing edge, including a run where the window is paused for a known number of clocks.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Byte offsets of the register slots; the software map depends on them.
    localparam int unsigned OFS_CTRL  = 32'h0;
    localparam int unsigned OFS_LIMIT = 32'h4;
    localparam int unsigned OFS_COUNT = 32'h8;
    localparam int unsigned OFS_ACK   = 32'hC;

    // Control bits in their bus positions: [2] reset arm, [1] kick, [0] run.
    typedef struct packed {
        logic arm;
        logic kick;
        logic run;
    } ctrl_bits_t;

    // One-cycle strobes decoded from a bus write.
    typedef struct packed {
        logic ctrl_wr;
        logic limit_wr;
        logic kick;
        logic ack;
    } strobe_t;

    typedef enum logic [2:0] {
        SEL_CTRL,
        SEL_LIMIT,
        SEL_COUNT,
        SEL_ACK,
        SEL_NONE
    } rsel_e;

    function automatic rsel_e decode_sel(input logic [31:0] ofs);
        rsel_e s;
        case (ofs)
            OFS_CTRL:  s = SEL_CTRL;
            OFS_LIMIT: s = SEL_LIMIT;
            OFS_COUNT: s = SEL_COUNT;
            OFS_ACK:   s = SEL_ACK;
            default:   s = SEL_NONE;
        endcase
        return s;
    endfunction

    // Readback image of the control register; the kick bit never reads as 1.
    function automatic logic [2:0] ctrl_image(input ctrl_bits_t c);
        return {c.arm, 1'b0, c.run};
    endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [2:0]        wbits,
    input  logic [DATA_W-1:0] limit_q,
    input  logic [DATA_W-1:0] count_q,
    output ctrl_bits_t        ctrl_q,
    output strobe_t           stb,
    output logic [DATA_W-1:0] rdata
);

    localparam int unsigned PAD_W = DATA_W - 3;

    rsel_e sel;
    logic  run_q;
    logic  arm_q;

    always_comb begin
        sel = decode_sel(32'(addr));
    end

    always_comb begin
        stb.ctrl_wr  = we && (sel == SEL_CTRL);
        stb.limit_wr = we && (sel == SEL_LIMIT);
        stb.kick     = we && (sel == SEL_CTRL) && wbits[1];
        stb.ack      = we && (sel == SEL_ACK)  && wbits[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            arm_q <= 1'b0;
        end else if (stb.ctrl_wr) begin
            run_q <= wbits[0];
            arm_q <= wbits[2];
        end
    end

    always_comb begin
        ctrl_q.arm  = arm_q;
        ctrl_q.kick = 1'b0;
        ctrl_q.run  = run_q;
    end

    always_comb begin
        case (sel)
            SEL_CTRL:  rdata = {{PAD_W{1'b0}}, ctrl_image(ctrl_q)};
            SEL_LIMIT: rdata = limit_q;
            SEL_COUNT: rdata = count_q;
            default:   rdata = '0;
        endcase
    end

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !stb.ctrl_wr |=> $stable({run_q, arm_q})) else $error("ctrl changed without write"); // R3

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  strobe_t           stb,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] limit_q,
    output logic [DATA_W-1:0] count_q,
    output logic              expire,
    output logic              irq_q
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    // An expiry only happens on a plain counting cycle; a limit write or
    // a kick on the same edge takes priority over it.
    always_comb begin
        expire = run && !stb.limit_wr && !stb.kick && (count_q == '0);
    end

    // The limit and count hold no guaranteed value after reset.
    always_ff @(posedge clk) begin
        if (stb.limit_wr) begin
            limit_q <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (stb.limit_wr) begin
            count_q <= wdata;
        end else if (stb.kick) begin
            count_q <= limit_q;
        end else if (run) begin
            if (count_q == '0) begin
                count_q <= limit_q;
            end else begin
                count_q <= count_q - ONE;
            end
        end
    end

    // Setting beats clearing when both land on the same edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else if (expire) begin
            irq_q <= 1'b1;
        end else if (stb.ack || stb.kick) begin
            irq_q <= 1'b0;
        end
    end

    AST_LIMIT_LOAD: assert property (@(posedge clk) disable iff (rst)
        stb.limit_wr |=> (count_q == $past(wdata))) else $error("limit write did not load count"); // R2

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (run && !stb.limit_wr && !stb.kick && (count_q != '0))
        |=> (count_q == $past(count_q) - ONE)) else $error("count did not step"); // R4

    AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!run && !stb.limit_wr && !stb.kick) |=> $stable(count_q)) else $error("count moved while off"); // R7

    AST_IRQ_ON_EXPIRE: assert property (@(posedge clk) disable iff (rst)
        expire |=> irq_q) else $error("expiry lost"); // R10

    AST_KICK_CLEARS_IRQ: assert property (@(posedge clk) disable iff (rst)
        stb.kick |=> !irq_q) else $error("kick left irq set"); // R6

endmodule

// File: rtl/wdt_grace.sv
module wdt_grace #(
    parameter int unsigned GRACE_CYCLES = 4096,
    parameter bit          HOLD_RESET   = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic arm,
    input  logic kick,
    input  logic expire,
    output logic sys_rst_q
);

    localparam int unsigned GW = (GRACE_CYCLES > 2) ? $clog2(GRACE_CYCLES) : 1;
    localparam logic [GW-1:0] LAST = GW'(GRACE_CYCLES - 1);

    logic          armed_q;
    logic [GW-1:0] gcnt_q;
    logic          advance;
    logic          fire;

    always_comb begin
        advance = armed_q && run && arm;
        fire    = advance && (gcnt_q == LAST);
    end

    always_ff @(posedge clk) begin
        if (rst || kick) begin
            armed_q <= 1'b0;
            gcnt_q  <= '0;
        end else if (advance) begin
            if (fire) begin
                armed_q <= 1'b0;
                gcnt_q  <= '0;
            end else begin
                gcnt_q <= gcnt_q + GW'(1);
            end
        end else if (expire && !armed_q) begin
            armed_q <= 1'b1;
            gcnt_q  <= '0;
        end
    end

    generate
        if (HOLD_RESET) begin : g_hold
            always_ff @(posedge clk) begin
                if (rst) begin
                    sys_rst_q <= 1'b0;
                end else if (fire) begin
                    sys_rst_q <= 1'b1;
                end
            end
        end else begin : g_pulse
            always_ff @(posedge clk) begin
                if (rst) begin
                    sys_rst_q <= 1'b0;
                end else begin
                    sys_rst_q <= fire;
                end
            end

            AST_RST_SINGLE: assert property (@(posedge clk) disable iff (rst)
                sys_rst_q |=> !sys_rst_q) else $error("reset pulse too long"); // R8
        end
    endgenerate

    AST_RST_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_rst_q) |-> $past(armed_q)) else $error("reset without window"); // R8

    AST_KICK_DISARM: assert property (@(posedge clk) disable iff (rst)
        kick |=> !armed_q) else $error("kick kept window"); // R6

    AST_GRACE_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (armed_q && !(run && arm) && !kick) |=> $stable(gcnt_q)) else $error("window moved while paused"); // R9

endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
    import wdt_pkg::*;
#(
    parameter int unsigned DATA_W       = 32,
    parameter int unsigned ADDR_W       = 4,
    parameter int unsigned GRACE_CYCLES = 4096,
    parameter bit          HOLD_RESET   = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              sys_rst_o
);

    ctrl_bits_t        ctrl;
    strobe_t           stb;
    logic [DATA_W-1:0] limit_q;
    logic [DATA_W-1:0] count_q;
    logic              expire;

    wdt_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .addr    (bus_addr),
        .we      (bus_we),
        .wbits   (bus_wdata[2:0]),
        .limit_q (limit_q),
        .count_q (count_q),
        .ctrl_q  (ctrl),
        .stb     (stb),
        .rdata   (bus_rdata)
    );

    wdt_counter #(
        .DATA_W (DATA_W)
    ) u_counter (
        .clk     (clk),
        .rst     (rst),
        .run     (ctrl.run),
        .stb     (stb),
        .wdata   (bus_wdata),
        .limit_q (limit_q),
        .count_q (count_q),
        .expire  (expire),
        .irq_q   (irq_o)
    );

    wdt_grace #(
        .GRACE_CYCLES (GRACE_CYCLES),
        .HOLD_RESET   (HOLD_RESET)
    ) u_grace (
        .clk       (clk),
        .rst       (rst),
        .run       (ctrl.run),
        .arm       (ctrl.arm),
        .kick      (stb.kick),
        .expire    (expire),
        .sys_rst_q (sys_rst_o)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!irq_o && !sys_rst_o)) else $error("outputs active after reset"); // R1

endmodule

// File: tb/tb_wdog_two_stage.sv
module tb_wdog_two_stage;

    localparam int CLK_PERIOD = 10;
    localparam int GRACE      = 4096;
    localparam int WATCHDOG   = 200000;

    localparam logic [3:0] A_CTRL  = 4'h0;
    localparam logic [3:0] A_LIMIT = 4'h4;
    localparam logic [3:0] A_COUNT = 4'h8;
    localparam logic [3:0] A_ACK   = 4'hC;

    localparam int K_READ = 0;
    localparam int K_IRQ  = 1;
    localparam int K_RST  = 2;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  bus_addr;
    logic        bus_we;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq_o;
    logic        sys_rst_o;

    logic        probe;
    sb_item_t    sb_q[$];
    int          checks   = 0;
    int          failures = 0;
    bit          done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_two_stage #(
        .DATA_W       (32),
        .ADDR_W       (4),
        .GRACE_CYCLES (GRACE),
        .HOLD_RESET   (1'b0)
    ) dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o),
        .sys_rst_o (sys_rst_o)
    );

    // Monitor: pops one expected item per probed cycle, away from the edge.
    always @(negedge clk) begin
        if (probe && !done) begin
            sb_item_t    it;
            logic [31:0] act;
            it = sb_q.pop_front();
            case (it.kind)
                K_READ:  act = bus_rdata;
                K_IRQ:   act = {31'b0, irq_o};
                default: act = {31'b0, sys_rst_o};
            endcase
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s actual=0x%0h expected=0x%0h", it.tag, act, it.exp);
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            probe  = 1'b0;
            bus_we = 1'b0;
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        probe     = 1'b0;
        bus_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
    endtask

    // Driver: one probed cycle, expected value pushed to the scoreboard.
    task automatic chk(input int kind, input logic [3:0] a, input logic [31:0] e, input string tag);
        sb_item_t it;
        @(posedge clk); #1;
        bus_we   = 1'b0;
        bus_addr = a;
        it.kind  = kind;
        it.exp   = e;
        it.tag   = tag;
        sb_q.push_back(it);
        probe    = 1'b1;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; probe = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // Reset state
        chk(K_READ, A_CTRL, 32'd0, "R1 ctrl after reset");
        chk(K_IRQ,  A_CTRL, 32'd0, "R1 irq after reset");
        chk(K_RST,  A_CTRL, 32'd0, "R1 sys_rst after reset");

        // Limit write loads count; count slot ignores writes
        wr(A_LIMIT, 32'd5);
        chk(K_READ, A_LIMIT, 32'd5, "R2 limit readback");
        chk(K_READ, A_COUNT, 32'd5, "R2 count loaded by limit write");
        wr(A_COUNT, 32'd99);
        chk(K_READ, A_COUNT, 32'd5, "R2 count write ignored");

        // Control readback
        wr(A_CTRL, 32'd4);
        chk(K_READ, A_CTRL, 32'd4, "R3 arm bit readback");
        wr(A_CTRL, 32'd6);
        chk(K_READ, A_CTRL, 32'd4, "R3 kick bit reads 0");

        // Countdown, expiry, reload
        wr(A_CTRL, 32'd1);
        for (int v = 5; v >= 0; v--) chk(K_READ, A_COUNT, 32'(v), "R4 countdown");
        chk(K_IRQ,  A_CTRL,  32'd1, "R4 irq on expiry");
        chk(K_READ, A_COUNT, 32'd4, "R4 counting continues after reload");

        // Acknowledge
        wr(A_ACK, 32'd0);
        chk(K_IRQ,  A_CTRL, 32'd1, "R5 ack with 0 no effect");
        wr(A_ACK, 32'd1);
        chk(K_IRQ,  A_CTRL, 32'd0, "R5 ack clears irq");
        chk(K_READ, A_ACK,  32'd0, "R5 ack slot reads 0");

        // Service while stopped, then hold
        wr(A_CTRL, 32'd2);
        idle(3);
        chk(K_READ, A_COUNT, 32'd5, "R7 count held while off");
        chk(K_IRQ,  A_CTRL,  32'd0, "R6 service clears irq");

        // Service while running reloads
        wr(A_CTRL, 32'd1);
        idle(2);
        wr(A_CTRL, 32'd3);
        chk(K_READ, A_COUNT, 32'd5, "R6 service reloads count");
        chk(K_READ, A_CTRL,  32'd1, "R3 ctrl after service write");
        wr(A_CTRL, 32'd0);
        idle(4);
        chk(K_READ, A_COUNT, 32'd2, "R7 count frozen after disable");

        // Limit write while running
        wr(A_CTRL, 32'd1);
        idle(2);
        wr(A_LIMIT, 32'd9);
        chk(K_READ, A_COUNT, 32'd9, "R2 running reload by limit write");
        chk(K_READ, A_COUNT, 32'd8, "R2 counting from new limit");
        chk(K_READ, A_LIMIT, 32'd9, "R2 new limit readback");
        wr(A_CTRL, 32'd2);

        // Same-edge collisions
        wr(A_LIMIT, 32'd3);
        wr(A_CTRL, 32'd1);
        idle(3);
        wr(A_ACK, 32'd1);
        chk(K_IRQ, A_CTRL, 32'd1, "R10 expiry beats ack on same edge");
        idle(2);
        wr(A_CTRL, 32'd3);
        chk(K_READ, A_COUNT, 32'd3, "R10 service on expiry edge reloads");
        chk(K_IRQ,  A_CTRL,  32'd0, "R10 service on expiry edge leaves irq clear");
        wr(A_CTRL, 32'd2);

        // Grace window fires, ack does not stop it
        wr(A_LIMIT, 32'd20);
        wr(A_CTRL, 32'd5);
        idle(25);
        wr(A_ACK, 32'd1);
        chk(K_IRQ, A_CTRL, 32'd0, "R9 ack during window");
        idle(GRACE - 7);
        chk(K_RST, A_CTRL, 32'd0, "R8 no reset one cycle early");
        chk(K_RST, A_CTRL, 32'd1, "R8 reset at window end");
        chk(K_RST, A_CTRL, 32'd0, "R8 reset is one cycle");

        // Window paused by clearing the reset function
        wr(A_CTRL, 32'd2);
        wr(A_CTRL, 32'd5);
        idle(30);
        wr(A_CTRL, 32'd1);
        idle(9);
        wr(A_CTRL, 32'd5);
        idle(GRACE - 11);
        chk(K_RST, A_CTRL, 32'd0, "R9 paused window not yet fired");
        chk(K_RST, A_CTRL, 32'd1, "R9 reset delayed by pause");

        // Service inside the window cancels it
        wr(A_CTRL, 32'd2);
        wr(A_CTRL, 32'd5);
        idle(30);
        wr(A_CTRL, 32'd7);
        idle(GRACE - 10);
        chk(K_RST, A_CTRL, 32'd0, "R6 serviced window gives no reset");
        wr(A_CTRL, 32'd0);

        idle(1);
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule